// File: doc/BRIEF.md
# Packed-Pixel Framebuffer Plotter

This block turns one pixel position into a single bit-setting update of a monochrome display buffer. The buffer is held in 16-bit words, and each word carries five 3-bit pixel fields, so a pixel column does not split on a power of two. The block divides the column by five. The quotient picks the word within a row, and the remainder picks the field inside that word. Bit 15 of every word is never part of any field.

A caller presents a 16-bit position word with a one-cycle strobe. The column sits in the upper byte and the row in the lower byte. An idle block takes the position, reads the addressed buffer word over a synchronous single-port memory port, ORs the field mask into it and writes the word back to the same address. Pixels that were already set stay set. While the update runs, `busy` is high and further strobes are dropped. A one-cycle `done` marks the cycle after the write-back.

Top module: `pxplot_top`

## Requirements
- R1: The position word carries the column x in bits 15:8 and the row y in bits 7:0. The word address is 0xF000 + 32*y + floor(x/5), taken modulo 2^16. For example, x=75 and x=79 at y=64 both give 0xF80F, and x=80 at y=64 gives 0xF810.
- R2: The field select is s = x mod 5. The OR mask for s = 0, 1, 2, 3, 4 is 0x7000, 0x0E00, 0x01C0, 0x0038, 0x0007 in that order. The written word differs from the read word only in bits of that mask.
- R3: The update is a read followed by a write. The read (mem_en=1, mem_we=0) is issued in the cycle after acceptance. Read data is expected one cycle after its address. The write (mem_en=1, mem_we=1) goes to the same address two cycles after the read and carries read data OR mask, so bits already set are kept.
- R4: Bit 15 of a written word always equals bit 15 of the word that was read.
- R5: `busy` is high for exactly three cycles per accepted position: the read, merge and write cycles.
- R6: `done` is high for exactly one cycle, the cycle right after the write-back.
- R7: A strobe that arrives while `busy` is high is ignored. It causes no memory access, and the buffer word it names is left unchanged.
- R8: A strobe that arrives in the cycle where `done` is high is accepted, and `busy` rises in the next cycle.
- R9: The quotient and remainder by five are exact for every column 0 to 255. A full row of 256 pixels therefore fills words 0 to 50 of the row with 0x7FFF and word 51 with 0x7000.
- R10: During and right after reset, `busy`, `done` and `mem_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coord_valid | input | 1 | One-cycle strobe marking a new position word |
| coord | input | 16 | Position: column in 15:8, row in 7:0 |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle pulse after the write-back |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable, high for the write-back |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Merged word for the write-back |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |

## Verification
Two functions of the block can fall in the same cycle: the completion pulse of one update and the acceptance of the next position. The bench provokes this by raising the strobe exactly in the cycle where `done` is seen high. It judges the result by whether `busy` rises in the next cycle and whether the second pixel's word gets its field. The opposite case is also driven: a strobe during the read cycle. That strobe must produce no extra memory access and must leave its target word at zero.

// File: rtl/pxplot_pkg.sv
package pxplot_pkg;

   // phases of one read-modify-write pixel update
   typedef enum logic [1:0] {
      PX_IDLE  = 2'd0,
      PX_READ  = 2'd1,
      PX_MERGE = 2'd2,
      PX_WRITE = 2'd3
   } px_phase_e;

   // selects how the column is split by the field count
   localparam int PX_DIV_RECIP = 0;
   localparam int PX_DIV_LONG  = 1;

endpackage

// File: rtl/pxplot_addr.sv
module pxplot_addr
   import pxplot_pkg::*;
#(
   parameter int                COORD_W   = 8,
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 16,
   parameter int                FIELD_W   = 3,
   parameter int                FIELDS    = 5,
   parameter int                ROW_WORDS = 32,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF000,
   parameter int                DIV_IMPL  = PX_DIV_RECIP
) (
   input  logic [COORD_W-1:0] x_in,
   input  logic [COORD_W-1:0] y_in,
   output logic [ADDR_W-1:0]  word_addr,
   output logic [DATA_W-1:0]  field_mask
);

   localparam int SEL_W     = $clog2(FIELDS);
   localparam int ROW_SHIFT = $clog2(ROW_WORDS);

   // elaboration-time parameter checks
   if (FIELDS < 2) begin : g_bad_fields
      $error("pxplot_addr: FIELDS must be at least 2");
   end
   if (FIELD_W * FIELDS > DATA_W - 1) begin : g_bad_pack
      $error("pxplot_addr: fields do not fit below the top bit of a word");
   end
   if ((1 << ROW_SHIFT) != ROW_WORDS) begin : g_bad_row
      $error("pxplot_addr: ROW_WORDS must be a power of two");
   end
   if (DIV_IMPL == PX_DIV_RECIP && (FIELDS != 5 || COORD_W > 10)) begin : g_bad_recip
      $error("pxplot_addr: reciprocal divider is exact only for five fields and up to 10-bit columns");
   end
   if (DIV_IMPL != PX_DIV_RECIP && DIV_IMPL != PX_DIV_LONG) begin : g_bad_impl
      $error("pxplot_addr: unknown DIV_IMPL");
   end

   logic [COORD_W-1:0] quot;
   logic [SEL_W-1:0]   sel;

   if (DIV_IMPL == PX_DIV_RECIP) begin : g_recip
      // x/5 == (x*205) >> 10, exact for every x below 1024
      localparam int PW = COORD_W + 8;
      logic [PW-1:0]      prod;
      logic [COORD_W-1:0] back;
      assign prod = PW'(x_in) * PW'(205);
      assign quot = COORD_W'(prod >> 10);
      assign back = x_in - COORD_W'(quot * COORD_W'(FIELDS));
      assign sel  = SEL_W'(back);
   end else begin : g_long
      // restoring division by the field count, one bit per step
      logic [SEL_W:0] part;
      always_comb begin
         part = '0;
         quot = '0;
         for (int i = COORD_W - 1; i >= 0; i--) begin
            part = {part[SEL_W-1:0], x_in[i]};
            if (part >= (SEL_W+1)'(FIELDS)) begin
               part    = part - (SEL_W+1)'(FIELDS);
               quot[i] = 1'b1;
            end
         end
         sel = part[SEL_W-1:0];
      end
   end

   // field 0 sits just below the top bit, later fields follow downwards
   logic [DATA_W-1:0] mask_tab [FIELDS];
   for (genvar f = 0; f < FIELDS; f++) begin : g_mask
      localparam int LSB = DATA_W - 1 - FIELD_W * (f + 1);
      assign mask_tab[f] = DATA_W'({FIELD_W{1'b1}}) << LSB;
   end

   always_comb begin
      field_mask = '0;
      for (int f = 0; f < FIELDS; f++) begin
         if (32'(sel) == f) field_mask = mask_tab[f];
      end
   end

   assign word_addr = BASE_ADDR + (ADDR_W'(y_in) << ROW_SHIFT) + ADDR_W'(quot);

endmodule

// File: rtl/pxplot_seq.sv
module pxplot_seq
   import pxplot_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic coord_valid,
   output logic accept,
   output logic rd_phase,
   output logic mrg_phase,
   output logic wr_phase,
   output logic busy,
   output logic done
);

   px_phase_e phase_q, phase_d;

   assign accept = coord_valid && (phase_q == PX_IDLE);

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PX_IDLE:  if (accept) phase_d = PX_READ;
         PX_READ:  phase_d = PX_MERGE;
         PX_MERGE: phase_d = PX_WRITE;
         PX_WRITE: phase_d = PX_IDLE;
         default:  phase_d = PX_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PX_IDLE;
         done    <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done    <= (phase_q == PX_WRITE);
      end
   end

   assign rd_phase  = (phase_q == PX_READ);
   assign mrg_phase = (phase_q == PX_MERGE);
   assign wr_phase  = (phase_q == PX_WRITE);
   assign busy      = (phase_q != PX_IDLE);

endmodule

// File: rtl/pxplot_dp.sv
module pxplot_dp #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              accept,
   input  logic              rd_phase,
   input  logic              mrg_phase,
   input  logic              wr_phase,
   input  logic [ADDR_W-1:0] next_addr,
   input  logic [DATA_W-1:0] next_mask,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata
);

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] word_q;

   // address and mask are captured with the position, so the divider
   // sits only between the input pins and these registers
   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
         mask_q <= '0;
         word_q <= '0;
      end else begin
         if (accept) begin
            addr_q <= next_addr;
            mask_q <= next_mask;
         end
         if (mrg_phase) word_q <= mem_rdata | mask_q;
      end
   end

   assign mem_en    = rd_phase | wr_phase;
   assign mem_we    = wr_phase;
   assign mem_addr  = addr_q;
   assign mem_wdata = wr_phase ? word_q : '0;

endmodule

// File: rtl/pxplot_top.sv
module pxplot_top
   import pxplot_pkg::*;
#(
   parameter int                COORD_W   = 8,
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 16,
   parameter int                FIELD_W   = 3,
   parameter int                FIELDS    = 5,
   parameter int                ROW_WORDS = 32,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF000,
   parameter int                DIV_IMPL  = PX_DIV_RECIP
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 coord_valid,
   input  logic [2*COORD_W-1:0] coord,
   output logic                 busy,
   output logic                 done,
   output logic                 mem_en,
   output logic                 mem_we,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [DATA_W-1:0]    mem_wdata,
   input  logic [DATA_W-1:0]    mem_rdata
);

   logic [COORD_W-1:0] col;
   logic [COORD_W-1:0] row;
   logic [ADDR_W-1:0]  calc_addr;
   logic [DATA_W-1:0]  calc_mask;
   logic               accept;
   logic               rd_phase;
   logic               mrg_phase;
   logic               wr_phase;

   assign col = coord[2*COORD_W-1:COORD_W];
   assign row = coord[COORD_W-1:0];

   pxplot_addr #(
      .COORD_W   (COORD_W),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .FIELD_W   (FIELD_W),
      .FIELDS    (FIELDS),
      .ROW_WORDS (ROW_WORDS),
      .BASE_ADDR (BASE_ADDR),
      .DIV_IMPL  (DIV_IMPL)
   ) addr_i (
      .x_in       (col),
      .y_in       (row),
      .word_addr  (calc_addr),
      .field_mask (calc_mask)
   );

   pxplot_seq seq_i (
      .clk         (clk),
      .rst         (rst),
      .coord_valid (coord_valid),
      .accept      (accept),
      .rd_phase    (rd_phase),
      .mrg_phase   (mrg_phase),
      .wr_phase    (wr_phase),
      .busy        (busy),
      .done        (done)
   );

   pxplot_dp #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) dp_i (
      .clk       (clk),
      .rst       (rst),
      .accept    (accept),
      .rd_phase  (rd_phase),
      .mrg_phase (mrg_phase),
      .wr_phase  (wr_phase),
      .next_addr (calc_addr),
      .next_mask (calc_mask),
      .mem_rdata (mem_rdata),
      .mem_en    (mem_en),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );

endmodule

// File: rtl/pxplot_chk.sv
module pxplot_chk #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 16,
   parameter int FIELD_W = 3
) (
   input logic              clk,
   input logic              rst,
   input logic              coord_valid,
   input logic              busy,
   input logic              done,
   input logic              mem_en,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [DATA_W-1:0] mem_rdata
);

   AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (rst)
      (mem_en && !mem_we) |-> ##2 (mem_en && mem_we && mem_addr == $past(mem_addr, 2))); // R3

   AST_KEEP_OLD: assert property (@(posedge clk) disable iff (rst)
      (mem_en && mem_we) |-> ((mem_wdata & $past(mem_rdata)) == $past(mem_rdata))); // R3

   AST_ONE_FIELD: assert property (@(posedge clk) disable iff (rst)
      (mem_en && mem_we) |-> ($countones(mem_wdata & ~$past(mem_rdata)) <= FIELD_W)); // R2

   AST_TOP_BIT: assert property (@(posedge clk) disable iff (rst)
      (mem_en && mem_we) |-> (mem_wdata[DATA_W-1] == $past(mem_rdata[DATA_W-1]))); // R4

   AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> ##3 !busy); // R5

   AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
      (mem_en && mem_we) |=> done); // R6

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R6

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !busy |-> !mem_en); // R7

   AST_ACCEPT: assert property (@(posedge clk) disable iff (rst)
      (coord_valid && !busy) |=> busy); // R8

endmodule

bind pxplot_top pxplot_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .FIELD_W (FIELD_W)
) chk_i (
   .clk         (clk),
   .rst         (rst),
   .coord_valid (coord_valid),
   .busy        (busy),
   .done        (done),
   .mem_en      (mem_en),
   .mem_we      (mem_we),
   .mem_addr    (mem_addr),
   .mem_wdata   (mem_wdata),
   .mem_rdata   (mem_rdata)
);

// File: tb/pxplot_top_tb_top.sv
module pxplot_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;
   localparam int WIN        = 4096;

   // {position, expected address, expected mask}
   localparam logic [47:0] VEC [8] = '{
      {16'h4B40, 16'hF80F, 16'h7000},
      {16'h4F40, 16'hF80F, 16'h0007},
      {16'h5040, 16'hF810, 16'h7000},
      {16'h0000, 16'hF000, 16'h7000},
      {16'hFF64, 16'hFCB3, 16'h7000},
      {16'h0701, 16'hF021, 16'h01C0},
      {16'h0D03, 16'hF062, 16'h0038},
      {16'h0602, 16'hF041, 16'h0E00}
   };

   logic        clk = 1'b0;
   logic        rst;
   logic        coord_valid;
   logic [15:0] coord;
   logic        busy, done, mem_en, mem_we;
   logic [15:0] mem_addr, mem_wdata, mem_rdata;

   logic [15:0] mem_q [WIN];
   logic [15:0] rdata_q;
   logic        clr, pre_en;
   logic [11:0] pre_idx;
   logic [15:0] pre_data;
   int          wr_cnt, acc_cnt;
   logic [15:0] last_wa, last_wd, last_ra;

   logic [15:0] ref_q [WIN];
   int          n_chk = 0;
   int          n_err = 0;
   bit          finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pxplot_top dut_i (
      .clk         (clk),
      .rst         (rst),
      .coord_valid (coord_valid),
      .coord       (coord),
      .busy        (busy),
      .done        (done),
      .mem_en      (mem_en),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .mem_rdata   (mem_rdata)
   );

   // buffer window 0xF000..0xFFFF, synchronous read
   always @(posedge clk) begin
      if (clr) begin
         for (int i = 0; i < WIN; i++) mem_q[i] <= '0;
         wr_cnt  <= 0;
         acc_cnt <= 0;
         last_wa <= '0;
         last_wd <= '0;
         last_ra <= '0;
         rdata_q <= '0;
      end else begin
         if (pre_en) mem_q[pre_idx] <= pre_data;
         if (mem_en) acc_cnt <= acc_cnt + 1;
         if (mem_en && mem_we) begin
            mem_q[mem_addr[11:0]] <= mem_wdata;
            wr_cnt  <= wr_cnt + 1;
            last_wa <= mem_addr;
            last_wd <= mem_wdata;
         end
         if (mem_en && !mem_we) begin
            rdata_q <= mem_q[mem_addr[11:0]];
            last_ra <= mem_addr;
         end
      end
   end
   assign mem_rdata = rdata_q;

   function automatic logic [15:0] f_addr(input int x, input int y);
      return 16'(32'hF000 + 32 * y + x / 5);
   endfunction

   function automatic logic [15:0] f_mask(input int x);
      return 16'h7000 >> (3 * (x % 5));
   endfunction

   task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   // starts and ends on a falling edge
   task automatic plot(input logic [15:0] c, input logic [15:0] ea, input logic [15:0] em, input bit full);
      logic [15:0] old;
      int bc;
      old = ref_q[ea[11:0]];
      coord_valid = 1'b1;
      coord       = c;
      @(negedge clk);
      coord_valid = 1'b0;
      bc = 0;
      while (busy && bc < 20) begin
         bc++;
         @(negedge clk);
      end
      ref_q[ea[11:0]] = old | em;
      check(last_wa == ea, "R1 write address", 32'(last_wa), 32'(ea));
      check(last_wd == (old | em), "R2 merged word", 32'(last_wd), 32'(old | em));
      if (full) begin
         check(last_ra == ea, "R3 read address", 32'(last_ra), 32'(ea));
         check(bc == 3, "R5 busy length", 32'(bc), 32'd3);
         check(done == 1'b1, "R6 done after write", 32'(done), 32'd1);
         @(negedge clk);
         check(done == 1'b0, "R6 done width", 32'(done), 32'd0);
      end
   endtask

   task automatic preload(input logic [15:0] a, input logic [15:0] d);
      pre_en   = 1'b1;
      pre_idx  = a[11:0];
      pre_data = d;
      @(negedge clk);
      pre_en = 1'b0;
      ref_q[a[11:0]] = d;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
         summary();
      end
   end

   initial begin
      logic [15:0] a_addr, b_addr;
      int acc0, wait_n;
      for (int i = 0; i < WIN; i++) ref_q[i] = '0;
      rst = 1'b1; clr = 1'b1; pre_en = 1'b0; pre_idx = '0; pre_data = '0;
      coord_valid = 1'b0; coord = '0;
      repeat (3) @(negedge clk);
      // R10 reset state
      check(busy == 1'b0, "R10 busy in reset", 32'(busy), 32'd0);
      check(done == 1'b0, "R10 done in reset", 32'(done), 32'd0);
      check(mem_en == 1'b0, "R10 mem_en in reset", 32'(mem_en), 32'd0);
      clr = 1'b0; rst = 1'b0;
      @(negedge clk);
      check(busy == 1'b0 && mem_en == 1'b0, "R10 idle after reset", 32'(busy), 32'd0);

      // table of directed positions: R1 R2 R3 R5 R6
      for (int v = 0; v < 8; v++) begin
         plot(VEC[v][47:32], VEC[v][31:16], VEC[v][15:0], 1'b1);
      end

      // R3 neighbouring fields accumulate in one word
      for (int x = 20; x < 23; x++) plot({8'(x), 8'd50}, f_addr(x, 50), f_mask(x), 1'b1);
      check(mem_q[f_addr(20, 50) & 16'h0FFF] == 16'h7FC0, "R3 preserved fields",
            32'(mem_q[f_addr(20, 50) & 16'h0FFF]), 32'h7FC0);

      // R4 top bit survives the merge
      preload(f_addr(10, 5), 16'h8000);
      plot({8'd10, 8'd5}, f_addr(10, 5), f_mask(10), 1'b1);
      check(last_wd[15] == 1'b1, "R4 top bit kept", 32'(last_wd[15]), 32'd1);

      // R7 strobe during busy is ignored
      a_addr = f_addr(30, 70);
      b_addr = f_addr(100, 70);
      acc0 = acc_cnt;
      coord_valid = 1'b1; coord = {8'd30, 8'd70};
      @(negedge clk);
      coord = {8'd100, 8'd70};
      @(negedge clk);
      coord_valid = 1'b0;
      repeat (8) @(negedge clk);
      ref_q[a_addr[11:0]] = ref_q[a_addr[11:0]] | f_mask(30);
      check(acc_cnt - acc0 == 2, "R7 access count", 32'(acc_cnt - acc0), 32'd2);
      check(mem_q[b_addr[11:0]] == 16'h0000, "R7 ignored word", 32'(mem_q[b_addr[11:0]]), 32'h0);
      check(last_wa == a_addr, "R7 only first written", 32'(last_wa), 32'(a_addr));
      check(busy == 1'b0, "R7 no second update", 32'(busy), 32'd0);

      // R8 strobe in the done cycle is accepted
      a_addr = f_addr(33, 71);
      b_addr = f_addr(34, 72);
      coord_valid = 1'b1; coord = {8'd33, 8'd71};
      @(negedge clk);
      coord_valid = 1'b0;
      wait_n = 0;
      while (!done && wait_n < 20) begin
         wait_n++;
         @(negedge clk);
      end
      ref_q[a_addr[11:0]] = ref_q[a_addr[11:0]] | f_mask(33);
      coord_valid = 1'b1; coord = {8'd34, 8'd72};
      @(negedge clk);
      coord_valid = 1'b0;
      check(busy == 1'b1, "R8 accepted with done", 32'(busy), 32'd1);
      repeat (5) @(negedge clk);
      ref_q[b_addr[11:0]] = ref_q[b_addr[11:0]] | f_mask(34);
      check(last_wa == b_addr, "R8 second address", 32'(last_wa), 32'(b_addr));
      check(mem_q[b_addr[11:0]] == f_mask(34), "R8 second word",
            32'(mem_q[b_addr[11:0]]), 32'(f_mask(34)));

      // R9 full row sweep
      for (int x = 0; x < 256; x++) plot({8'(x), 8'd110}, f_addr(x, 110), f_mask(x), 1'b0);
      @(negedge clk);
      for (int q = 0; q < 52; q++) begin
         logic [15:0] e;
         e = (q < 51) ? 16'h7FFF : 16'h7000;
         check(mem_q[f_addr(5 * q, 110) & 16'h0FFF] == e, "R9 row word",
               32'(mem_q[f_addr(5 * q, 110) & 16'h0FFF]), 32'(e));
      end

      // square outline, then the whole window against the reference
      for (int x = 40; x <= 60; x++) begin
         plot({8'(x), 8'd20}, f_addr(x, 20), f_mask(x), 1'b0);
         plot({8'(x), 8'd40}, f_addr(x, 40), f_mask(x), 1'b0);
      end
      for (int y = 21; y < 40; y++) begin
         plot({8'd40, 8'(y)}, f_addr(40, y), f_mask(40), 1'b0);
         plot({8'd60, 8'(y)}, f_addr(60, y), f_mask(60), 1'b0);
      end
      repeat (2) @(negedge clk);
      begin
         int bad;
         bad = 0;
         for (int i = 0; i < WIN; i++) begin
            if (ref_q[i] != 16'h0000)
               check(mem_q[i] == ref_q[i], "R9 square word", 32'(mem_q[i]), 32'(ref_q[i]));
            else if (mem_q[i] != 16'h0000)
               bad++;
         end
         check(bad == 0, "R1 untouched words", 32'(bad), 32'd0);
      end
      summary();
   end

endmodule